// File: doc/BRIEF.md
# DMA Channel Interrupt Controller

This block gathers the event pulses of one DMA channel into a twelve-bit status register and drives one level-sensitive interrupt line. Each status bit can be blocked by a mask bit. Software cannot write the mask directly. It sets mask bits through a write-only disable port and clears them through a write-only enable port. The block also keeps two 8-bit completion counters, one for source descriptors and one for destination descriptors. When a counter wraps, it raises its own error bit in the status register. Reading a counter returns its value and clears it.

A simple 32-bit register port carries the accesses. The requester pulses `reg_req` for one cycle. In the next cycle the block raises `reg_ack` and presents `reg_rdata`. An access control state machine has two named states. In `S_IDLE` it accepts a request and decodes it (transition *accept*: `S_IDLE` to `S_ACK` when `reg_req` is high). In `S_ACK` it acknowledges (transition *complete*: `S_ACK` to `S_IDLE`, taken unconditionally). A request made while the machine is in `S_ACK` is dropped. If an access hits an address with no register, or does not enable all four byte lanes, the access has no effect and raises the invalid-access status bit.

Top module: `dma_irq_ctrl`

## Requirements
- R1: Status bit positions are: 0 invalid access, 1 source descriptor done, 2 destination descriptor done, 3 byte-count overflow, 4 source counter wrap, 5 destination counter wrap, 6 source descriptor read error, 7 destination descriptor read error, 8 data read error, 9 data write error, 10 transfer done, 11 paused. A pulse on `ev_chan[i]` sets status bit i only for i in {3,6,7,8,9,10,11}. Bits 0,1,2,4,5 of `ev_chan` have no effect.
- R2: `irq` is high exactly when some status bit is 1 while its mask bit is 0.
- R3: A write to the enable port (0x108) clears the mask bits where the written data is 1. A write to the disable port (0x10C) sets them. A write to the mask register (0x104) changes nothing.
- R4: Each `ev_src_dscr_done` cycle increments the 8-bit source counter (0x190) and sets status bit 1. An increment from 255 wraps to 0 and also sets status bit 4.
- R5: `ev_dst_dscr_done` acts in the same way on the destination counter (0x194), status bit 2 and status bit 5.
- R6: An access to an unmapped or misaligned address, or with `reg_be` not 4'hF, sets status bit 0, changes no other state and returns read data 0.
- R7: Writing 1 to a status bit (0x100) clears it. A hardware set in the same cycle wins, so the bit stays 1.
- R8: After reset the mask reads 0xFFF, and the status and both counters read 0.
- R9: A counter read returns the value held before the access and leaves the counter at 0. If an increment arrives in the same cycle, the counter is left at 1 and no wrap is flagged.
- R10: `reg_ack` is high for exactly the one cycle after an accepted request, with `reg_rdata` valid in that cycle. A request during the acknowledge cycle is ignored. Reads of the enable and disable ports return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Access request, one-cycle pulse |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_be | input | 4 | Byte enables; only 4'hF is a legal access |
| reg_addr | input | AW (12) | Byte address |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data, valid while reg_ack is high |
| reg_ack | output | 1 | Access acknowledge |
| ev_src_dscr_done | input | 1 | Source descriptor completed |
| ev_dst_dscr_done | input | 1 | Destination descriptor completed |
| ev_chan | input | 12 | Other channel event pulses, by status bit position |
| irq | output | 1 | Level interrupt |

## Verification
Several properties are checked on every cycle by assertions:
- a hardware set that arrives with a write-1-to-clear still leaves the bit set;
- enable and disable writes reach the addressed mask bits on the following cycle;
- a counter wrap leaves zero behind;
- an acknowledge never lasts two cycles;
- an invalid access always lands in bit 0.

Other behaviours can only be shown by the bench's scenarios:
- the exact status bit layout and the bits of `ev_chan` that are ignored;
- the return value of a read that also clears a counter, including one that coincides with an increment;
- a mask write that has no effect;
- a request dropped during the acknowledge cycle.

A behavioural model in the bench also compares `irq`, `reg_ack` and `reg_rdata` on every clock.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
    localparam int NEV = 12;

    localparam int B_BADACC = 0;
    localparam int B_SDONE  = 1;
    localparam int B_DDONE  = 2;
    localparam int B_SWRAP  = 4;
    localparam int B_DWRAP  = 5;

    // event bits that come straight from the channel
    localparam logic [NEV-1:0] EXT_SET_MASK = 12'hFC8;

    localparam logic [11:0] OFF_STATUS = 12'h100;
    localparam logic [11:0] OFF_MASK   = 12'h104;
    localparam logic [11:0] OFF_ENABLE = 12'h108;
    localparam logic [11:0] OFF_DISABL = 12'h10C;
    localparam logic [11:0] OFF_SCOUNT = 12'h190;
    localparam logic [11:0] OFF_DCOUNT = 12'h194;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_ACK  = 1'b1
    } acc_state_t;

    typedef enum logic [2:0] {
        T_NONE,
        T_STAT,
        T_MASK,
        T_EN,
        T_DIS,
        T_SCNT,
        T_DCNT
    } reg_tgt_t;
endpackage

// File: rtl/dmairq_regif.sv
module dmairq_regif
    import dmairq_pkg::*;
#(
    parameter int AW  = 12,
    parameter int DW  = 32,
    parameter int CW  = 8,
    parameter int NCH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                we,
    input  logic [3:0]          be,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    input  logic [NEV-1:0]      rd_status,
    input  logic [NEV-1:0]      rd_mask,
    input  logic [NCH*CW-1:0]   rd_cnt,
    output logic [DW-1:0]       rdata,
    output logic                ack,
    output logic [NEV-1:0]      w1c_vec,
    output logic [NEV-1:0]      en_vec,
    output logic [NEV-1:0]      dis_vec,
    output logic                bad_acc,
    output logic [NCH-1:0]      cnt_rd
);
    acc_state_t state_q, state_d;
    reg_tgt_t   tgt;
    logic       accept;
    logic       legal;
    logic [DW-1:0] rd_mux;

    // address decode
    always_comb begin
        tgt = T_NONE;
        if (AW'(OFF_STATUS) == addr) tgt = T_STAT;
        if (AW'(OFF_MASK)   == addr) tgt = T_MASK;
        if (AW'(OFF_ENABLE) == addr) tgt = T_EN;
        if (AW'(OFF_DISABL) == addr) tgt = T_DIS;
        if (AW'(OFF_SCOUNT) == addr) tgt = T_SCNT;
        if (AW'(OFF_DCOUNT) == addr) tgt = T_DCNT;
    end

    always_comb begin
        rd_mux = '0;
        unique case (tgt)
            T_STAT:  rd_mux = DW'(rd_status);
            T_MASK:  rd_mux = DW'(rd_mask);
            T_SCNT:  rd_mux = DW'(rd_cnt[CW-1:0]);
            T_DCNT:  rd_mux = DW'(rd_cnt[2*CW-1:CW]);
            default: rd_mux = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req) state_d = S_ACK;
            S_ACK:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept  = (state_q == S_IDLE) && req;
        legal   = accept && (tgt != T_NONE) && (be == 4'hF);
        ack     = (state_q == S_ACK);
        bad_acc = accept && !legal;
        w1c_vec = (legal && we && tgt == T_STAT) ? wdata[NEV-1:0] : '0;
        en_vec  = (legal && we && tgt == T_EN)   ? wdata[NEV-1:0] : '0;
        dis_vec = (legal && we && tgt == T_DIS)  ? wdata[NEV-1:0] : '0;
        cnt_rd  = '0;
        cnt_rd[0] = legal && !we && tgt == T_SCNT;
        cnt_rd[1] = legal && !we && tgt == T_DCNT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (accept) rdata <= (legal && !we) ? rd_mux : '0;
    end

    p_ack_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    p_ack_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ack);
endmodule

// File: rtl/dmairq_cnt.sv
module dmairq_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          clr,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    localparam logic [CW-1:0] CMAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= inc ? CW'(1) : '0;
        else if (inc) cnt <= cnt + CW'(1);
    end

    assign wrap = inc && !clr && (cnt == CMAX);

    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));
    p_clr_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> (cnt == CW'(1)));
endmodule

// File: rtl/dmairq_stat.sv
module dmairq_stat
    import dmairq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] set_vec,
    input  logic [NEV-1:0] w1c_vec,
    input  logic [NEV-1:0] en_vec,
    input  logic [NEV-1:0] dis_vec,
    output logic [NEV-1:0] status,
    output logic [NEV-1:0] mask,
    output logic           irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '1;
        end else begin
            status <= (status & ~w1c_vec) | set_vec;
            mask   <= (mask & ~en_vec) | dis_vec;
        end
    end

    assign irq = |(status & ~mask);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));
    p_en_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|en_vec) |=> ((mask & $past(en_vec)) == '0));
    p_dis_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|dis_vec) |=> ((mask & $past(dis_vec)) == $past(dis_vec)));
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dmairq_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_req,
    input  logic          reg_we,
    input  logic [3:0]    reg_be,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          reg_ack,
    input  logic          ev_src_dscr_done,
    input  logic          ev_dst_dscr_done,
    input  logic [11:0]   ev_chan,
    output logic          irq
);
    localparam int NCH = 2;

    logic [NEV-1:0]    status, mask, set_vec, w1c_vec, en_vec, dis_vec;
    logic [NCH*CW-1:0] cnt_flat;
    logic [NCH-1:0]    cnt_rd, cnt_inc, cnt_wrap;
    logic              bad_acc;

    assign cnt_inc = {ev_dst_dscr_done, ev_src_dscr_done};

    dmairq_regif #(.AW(AW), .DW(DW), .CW(CW), .NCH(NCH)) u_regif (
        .clk(clk), .rst_n(rst_n),
        .req(reg_req), .we(reg_we), .be(reg_be), .addr(reg_addr), .wdata(reg_wdata),
        .rd_status(status), .rd_mask(mask), .rd_cnt(cnt_flat),
        .rdata(reg_rdata), .ack(reg_ack),
        .w1c_vec(w1c_vec), .en_vec(en_vec), .dis_vec(dis_vec),
        .bad_acc(bad_acc), .cnt_rd(cnt_rd)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_cnt
        dmairq_cnt #(.CW(CW)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .inc(cnt_inc[g]), .clr(cnt_rd[g]),
            .cnt(cnt_flat[g*CW +: CW]), .wrap(cnt_wrap[g])
        );
    end

    always_comb begin
        set_vec = ev_chan & EXT_SET_MASK;
        set_vec[B_BADACC] = bad_acc;
        set_vec[B_SDONE]  = cnt_inc[0];
        set_vec[B_DDONE]  = cnt_inc[1];
        set_vec[B_SWRAP]  = cnt_wrap[0];
        set_vec[B_DWRAP]  = cnt_wrap[1];
    end

    dmairq_stat u_stat (
        .clk(clk), .rst_n(rst_n),
        .set_vec(set_vec), .w1c_vec(w1c_vec), .en_vec(en_vec), .dis_vec(dis_vec),
        .status(status), .mask(mask), .irq(irq)
    );

    p_badacc_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_acc |=> status[B_BADACC]);
    p_done_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_dst_dscr_done |=> status[B_DDONE]);
endmodule

// File: tb/sim_dma_irq_ctrl.sv
`timescale 1ns/1ps
module sim_dma_irq_ctrl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_req = 0, reg_we = 0;
    logic [3:0]  reg_be = 4'hF;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_ack, irq;
    logic        ev_s = 0, ev_d = 0;
    logic [11:0] ev_c = '0;

    int n_run = 0, n_fail = 0;
    bit cmp_on = 0;

    always #2.5 clk = ~clk;

    dma_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we), .reg_be(reg_be),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
        .ev_src_dscr_done(ev_s), .ev_dst_dscr_done(ev_d), .ev_chan(ev_c), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_stat, m_mask, m_sc, m_dc, m_rdata;
    bit m_ack;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stat = 0; m_mask = 'hFFF; m_sc = 0; m_dc = 0; m_rdata = 0; m_ack = 0;
        end else begin
            bit acc, hit, ok, sclr, dclr, sw, dw;
            int rv, setv, w1c;
            acc = reg_req && !m_ack;
            hit = 1; rv = 0;
            case (reg_addr)
                12'h100: rv = m_stat;
                12'h104: rv = m_mask;
                12'h108, 12'h10C: rv = 0;
                12'h190: rv = m_sc;
                12'h194: rv = m_dc;
                default: hit = 0;
            endcase
            ok = acc && hit && reg_be == 4'hF;
            sclr = ok && !reg_we && reg_addr == 12'h190;
            dclr = ok && !reg_we && reg_addr == 12'h194;
            sw = ev_s && !sclr && m_sc == 255;
            dw = ev_d && !dclr && m_dc == 255;
            setv = (ev_c & 'hFC8) | ((acc && !ok) ? 1 : 0) | (ev_s << 1) | (ev_d << 2)
                 | (sw << 4) | (dw << 5);
            w1c = (ok && reg_we && reg_addr == 12'h100) ? (reg_wdata & 'hFFF) : 0;
            if (ok && reg_we && reg_addr == 12'h108) m_mask = m_mask & ~(reg_wdata & 'hFFF);
            if (ok && reg_we && reg_addr == 12'h10C) m_mask = m_mask | (reg_wdata & 'hFFF);
            m_sc = sclr ? int'(ev_s) : (m_sc + int'(ev_s)) % 256;
            m_dc = dclr ? int'(ev_d) : (m_dc + int'(ev_d)) % 256;
            m_stat = (m_stat & ~w1c) | setv;
            if (acc) m_rdata = (ok && !reg_we) ? rv : 0;
            m_ack = acc;
        end
    end

    always @(negedge clk) if (cmp_on) begin
        chk("R2 irq vs model", 32'(irq), 32'((m_stat & ~m_mask) != 0));
        chk("R10 ack vs model", 32'(reg_ack), 32'(m_ack));
        chk("R10 rdata vs model", reg_rdata, m_rdata);
    end

    task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d,
                          output logic [31:0] rd, input logic [3:0] b = 4'hF,
                          input logic es = 0, input logic [11:0] ec = 0);
        @(negedge clk);
        reg_req = 1; reg_we = w; reg_addr = a; reg_wdata = d; reg_be = b;
        ev_s = es; ev_c = ec;
        @(negedge clk);
        reg_req = 0; reg_be = 4'hF; ev_s = 0; ev_c = 0;
        rd = reg_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] x;
        access(1, a, d, x);
    endtask

    task automatic rd_chk(string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] x;
        access(0, a, 0, x);
        chk(tag, x, exp);
    endtask

    task automatic hold_ev(input logic s, input logic d, input logic [11:0] c, input int n);
        @(negedge clk);
        ev_s = s; ev_d = d; ev_c = c;
        repeat (n) @(negedge clk);
        ev_s = 0; ev_d = 0; ev_c = 0;
    endtask

    initial begin
        #(200000 * 5);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] x;
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_on = 1;
        // R8 reset values
        chk("R8 irq after reset", 32'(irq), 0);
        rd_chk("R8 status reset", 12'h100, 0);
        rd_chk("R8 mask reset", 12'h104, 32'hFFF);
        rd_chk("R8 src count reset", 12'h190, 0);
        rd_chk("R8 dst count reset", 12'h194, 0);
        // R1 layout and ignored channel bits
        hold_ev(0, 0, 12'h037, 1);
        rd_chk("R1 ignored ev_chan bits", 12'h100, 0);
        hold_ev(0, 0, 12'hFFF, 1);
        rd_chk("R1 channel events", 12'h100, 32'hFC8);
        chk("R2 masked irq low", 32'(irq), 0);
        // R3 mask ports
        wr(12'h108, 32'h008);
        chk("R2 unmasked irq high", 32'(irq), 1);
        rd_chk("R3 enable clears mask", 12'h104, 32'hFF7);
        wr(12'h10C, 32'h008);
        chk("R3 disable masks irq", 32'(irq), 0);
        wr(12'h104, 32'h000);
        rd_chk("R3 mask write ignored", 12'h104, 32'hFFF);
        // R7 write-one-to-clear and set priority
        wr(12'h100, 32'h008);
        rd_chk("R7 w1c clears", 12'h100, 32'hFC0);
        access(1, 12'h100, 32'h040, x, 4'hF, 0, 12'h040);
        rd_chk("R7 set wins over clear", 12'h100, 32'hFC0);
        wr(12'h100, 32'hFFF);
        rd_chk("R7 all cleared", 12'h100, 0);
        // R4 source counter
        for (int i = 0; i < 3; i++) hold_ev(1, 0, 0, 1);
        rd_chk("R4 src count", 12'h190, 3);
        rd_chk("R9 read clears", 12'h190, 0);
        rd_chk("R4 src done flag", 12'h100, 32'h002);
        wr(12'h100, 32'hFFF);
        hold_ev(1, 0, 0, 256);
        rd_chk("R4 src wrap count", 12'h190, 0);
        rd_chk("R4 src wrap flag", 12'h100, 32'h012);
        // R5 destination counter
        hold_ev(0, 1, 0, 255);
        rd_chk("R5 dst count 255", 12'h194, 255);
        hold_ev(0, 1, 0, 256);
        rd_chk("R5 dst wrap flag", 12'h100, 32'h036);
        wr(12'h100, 32'hFFF);
        // R9 read with simultaneous increment
        for (int i = 0; i < 5; i++) hold_ev(1, 0, 0, 1);
        access(0, 12'h190, 0, x, 4'hF, 1, 0);
        chk("R9 read returns old value", x, 5);
        rd_chk("R9 counter left at one", 12'h190, 1);
        wr(12'h100, 32'hFFF);
        // R6 invalid accesses
        rd_chk("R6 unmapped read data", 12'h200, 0);
        rd_chk("R6 unmapped sets bit0", 12'h100, 32'h001);
        wr(12'h100, 32'h001);
        access(1, 12'h108, 32'hFFF, x, 4'h3);
        rd_chk("R6 partial write no effect", 12'h104, 32'hFFF);
        rd_chk("R6 partial write sets bit0", 12'h100, 32'h001);
        wr(12'h100, 32'h001);
        rd_chk("R6 misaligned read data", 12'h102, 0);
        rd_chk("R6 misaligned sets bit0", 12'h100, 32'h001);
        wr(12'h100, 32'h001);
        // R10 write-only port reads and dropped request
        rd_chk("R10 enable port reads 0", 12'h108, 0);
        @(negedge clk);
        reg_req = 1; reg_we = 1; reg_addr = 12'h108; reg_wdata = 32'h001;
        @(negedge clk);
        chk("R10 ack after request", 32'(reg_ack), 1);
        reg_wdata = 32'h002;
        @(negedge clk);
        reg_req = 0;
        chk("R10 ack one cycle", 32'(reg_ack), 0);
        rd_chk("R10 request in ack dropped", 12'h104, 32'hFFE);
        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule